// File: doc/BRIEF.md
# Separable Two-Dimensional Approximate Cosine Transform

This block transforms a square tile of signed samples, 8×8 or 16×16, into a two-dimensional approximate frequency representation. It uses no multipliers. Every coefficient of the underlying one-dimensional transform is 0, +1 or −1, so both passes are pure add/subtract networks. One instance of the one-dimensional stage processes each incoming row as it arrives. A double-banked corner-turn memory then turns the row results into columns. A second, identical stage transforms each column.

A producer presents one whole row of N samples per clock, with `in_valid`. It marks the first row of every tile with `in_sob`. The block returns one column of N coefficients per clock, with `out_valid`, and marks the last column of each tile with `out_last`. While one bank of the corner-turn memory drains columns, the other bank fills with the next tile, so tiles can follow each other without gaps. No normalisation is applied: outputs carry the full integer growth of both passes.

The corner-turn control is two small state machines. The fill machine has the states FILL_IDLE and FILL_ROWS:
- It leaves FILL_IDLE when it sees a valid row that carries `in_sob`.
- It goes back to FILL_IDLE when row N−1 is written. At that point it swaps the write bank and signals that the tile is complete.
- A valid row that carries `in_sob` while in FILL_ROWS restarts the count at row 0 and stays in FILL_ROWS.

The drain machine has the states DRAIN_WAIT and DRAIN_COLS:
- It moves to DRAIN_COLS on a tile-complete signal.
- It steps through columns 0 to N−1.
- After column N−1 it either starts the next completed tile at once or returns to DRAIN_WAIT.

Top module: `dct2d_rowcol`

## Requirements
- R1: For N=8, each pass maps x0..x7 to y0..y7 using a_i = x_i + x_(7−i) and b_i = x_i − x_(7−i), i = 0..3. The outputs are:
  - y0 = a0+a1+a2+a3 and y4 = a0−a1−a2+a3
  - y2 = a0−a3 and y6 = a1−a2
  - y1 = b0+b1 and y7 = b0−b1
  - y3 = b2+b3 and y5 = b2−b3
- R2: For N=16, with p_i = x_i + x_(15−i) and m_i = x_i − x_(15−i), i = 0..7: even output 2k is output k of the 8-point map applied to p, and odd output 2k+1 is output k of the 8-point map applied to m.
- R3: Let X[r][c] be sample c of input row r, and T the N-point matrix. The word at lane v of output column u is Z[v][u] = Σ_r T[v][r] · Σ_c T[u][c]·X[r][c]. Input sample c sits at `in_row[c*IW +: IW]` and lane v at `out_col[v*OW +: OW]`, both two's complement. Columns leave in order u = 0..N−1.
- R4: Take the rising edge that samples the first row of a tile when the block is idle. Column 0 of that tile is presented after the (N+1)-th following rising edge. The remaining columns follow on consecutive cycles.
- R5: `out_last` is high exactly in the cycle of column N−1 of each tile, and never while `out_valid` is low.
- R6: Tiles entered back to back, one row per cycle, leave as an uninterrupted stream of 2N valid columns for two tiles.
- R7: A valid row without `in_sob` arriving while no tile is being filled is discarded and produces no output.
- R8: A valid row with `in_sob` arriving in the middle of a tile abandons the partial tile. The new row becomes row 0, and only the complete tile is output.
- R9: Cycles with `in_valid` low inside a tile pause the fill without losing or reordering rows.
- R10: During and directly after reset, `out_valid` and `out_last` are low.
- R11: Output width is IW + 2·log2(N). Tiles of all most-negative or all most-positive samples produce exact results with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Row present on `in_row` this cycle |
| in_sob | input | 1 | Row is the first row of a tile |
| in_row | input | N*IW | N signed samples of one row |
| out_valid | output | 1 | Column present on `out_col` |
| out_last | output | 1 | Column is the last of its tile |
| out_col | output | N*(IW+2*log2(N)) | N signed coefficients of one column |

## Verification
The hardest situation to reach from the ports is the bank hand-over. This is the cycle in which the drain machine reads the final column of one bank while the fill machine writes the final row of the other bank. Only strictly back-to-back tiles at full row rate hit that exact cycle. The stimulus streams two tiles with no idle cycle between them and requires an unbroken 2N-column run. Abandoned tiles and stray rows without a start flag are also driven, and the bench confirms that they leave no trace in the output stream.

// File: rtl/dct2d_pkg.sv
`timescale 1ns/1ps
package dct2d_pkg;
    // fill side of the corner-turn memory
    typedef enum logic { FILL_IDLE, FILL_ROWS } fill_state_t;
    // drain side of the corner-turn memory
    typedef enum logic { DRAIN_WAIT, DRAIN_COLS } drain_state_t;
endpackage

// File: rtl/dct2d_kernel8.sv
`timescale 1ns/1ps
// Combinational 8-point multiplierless transform: 18 add/subtract operations.
module dct2d_kernel8 #(
    parameter int W = 8
) (
    input  logic signed [W-1:0] x [8],
    output logic signed [W+2:0] y [8]
);
    logic [W:0]   a [4];
    logic [W:0]   b [4];
    logic [W+1:0] s03;
    logic [W+1:0] s12;

    function automatic logic [W+2:0] ext1(input logic [W:0] v);
        return {{2{v[W]}}, v};
    endfunction

    function automatic logic [W+2:0] ext2(input logic [W+1:0] v);
        return {v[W+1], v};
    endfunction

    // R1: mirror butterflies
    for (genvar i = 0; i < 4; i++) begin : g_bfly
        assign a[i] = {x[i][W-1], x[i]} + {x[7-i][W-1], x[7-i]};
        assign b[i] = {x[i][W-1], x[i]} - {x[7-i][W-1], x[7-i]};
    end

    assign s03 = {a[0][W], a[0]} + {a[3][W], a[3]};
    assign s12 = {a[1][W], a[1]} + {a[2][W], a[2]};

    assign y[0] = ext2(s03) + ext2(s12);
    assign y[4] = ext2(s03) - ext2(s12);
    assign y[2] = ext1(a[0]) - ext1(a[3]);
    assign y[6] = ext1(a[1]) - ext1(a[2]);
    assign y[1] = ext1(b[0]) + ext1(b[1]);
    assign y[7] = ext1(b[0]) - ext1(b[1]);
    assign y[3] = ext1(b[2]) + ext1(b[3]);
    assign y[5] = ext1(b[2]) - ext1(b[3]);
endmodule

// File: rtl/dct2d_stage.sv
`timescale 1ns/1ps
// One registered 1D pass; N selects the 8-point kernel or the 16-point composition.
module dct2d_stage #(
    parameter  int N    = 8,
    parameter  int W    = 8,
    localparam int GROW = $clog2(N),
    localparam int OW   = W + GROW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_v,
    input  logic                 in_tag,
    input  logic signed [W-1:0]  d [N],
    output logic                 out_v,
    output logic                 out_tag,
    output logic signed [OW-1:0] q [N]
);
    logic signed [OW-1:0] q_c [N];

    if (N == 8) begin : g_n8
        dct2d_kernel8 #(.W(W)) u_k8 (.x(d), .y(q_c));
    end else begin : g_n16
        // R2: input butterfly, two 8-point kernels, interleaved outputs
        logic signed [W:0]   ev_in  [8];
        logic signed [W:0]   od_in  [8];
        logic signed [W+3:0] ev_out [8];
        logic signed [W+3:0] od_out [8];
        for (genvar i = 0; i < 8; i++) begin : g_in
            assign ev_in[i] = {d[i][W-1], d[i]} + {d[N-1-i][W-1], d[N-1-i]};
            assign od_in[i] = {d[i][W-1], d[i]} - {d[N-1-i][W-1], d[N-1-i]};
            assign q_c[2*i]   = ev_out[i];
            assign q_c[2*i+1] = od_out[i];
        end
        dct2d_kernel8 #(.W(W+1)) u_even (.x(ev_in), .y(ev_out));
        dct2d_kernel8 #(.W(W+1)) u_odd  (.x(od_in), .y(od_out));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_v   <= 1'b0;
            out_tag <= 1'b0;
        end else begin
            out_v   <= in_v;
            out_tag <= in_v & in_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (in_v) q <= q_c;
    end
endmodule

// File: rtl/dct2d_transpose.sv
`timescale 1ns/1ps
// Double-banked corner-turn memory: whole rows in, whole columns out.
module dct2d_transpose
    import dct2d_pkg::*;
#(
    parameter  int N  = 8,
    parameter  int W  = 11,
    localparam int RW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wv,
    input  logic                wsob,
    input  logic signed [W-1:0] wdata [N],
    output logic                rv,
    output logic                rlast,
    output logic signed [W-1:0] rdata [N]
);
    localparam logic [RW-1:0] LAST = RW'(N - 1);

    logic [W-1:0] mem [2][N][N];

    fill_state_t  fill_q,  fill_d;
    drain_state_t drain_q, drain_d;
    logic [RW-1:0] row_q, row_d;
    logic [RW-1:0] col_q, col_d;
    logic          wbank_q, wbank_d;
    logic          rbank_q, rbank_d;
    logic          tile_done;
    logic          wr_en;
    logic [RW-1:0] wr_idx;

    assign wr_en  = wv && (wsob || fill_q == FILL_ROWS);
    assign wr_idx = wsob ? '0 : row_q;

    // fill machine: next state
    always_comb begin
        fill_d    = fill_q;
        row_d     = row_q;
        wbank_d   = wbank_q;
        tile_done = 1'b0;
        unique case (fill_q)
            FILL_IDLE: begin
                if (wv && wsob) begin
                    fill_d = FILL_ROWS;
                    row_d  = RW'(1);
                end
            end
            FILL_ROWS: begin
                if (wv) begin
                    if (wsob) begin
                        row_d = RW'(1);
                    end else if (row_q == LAST) begin
                        tile_done = 1'b1;
                        fill_d    = FILL_IDLE;
                        row_d     = '0;
                        wbank_d   = ~wbank_q;
                    end else begin
                        row_d = row_q + RW'(1);
                    end
                end
            end
        endcase
    end

    // drain machine: next state
    always_comb begin
        drain_d = drain_q;
        col_d   = col_q;
        rbank_d = rbank_q;
        unique case (drain_q)
            DRAIN_WAIT: begin
                if (tile_done) begin
                    drain_d = DRAIN_COLS;
                    col_d   = '0;
                    rbank_d = wbank_q;
                end
            end
            DRAIN_COLS: begin
                if (col_q == LAST) begin
                    col_d = '0;
                    if (tile_done) rbank_d = wbank_q;
                    else           drain_d = DRAIN_WAIT;
                end else begin
                    col_d = col_q + RW'(1);
                end
            end
        endcase
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q  <= FILL_IDLE;
            drain_q <= DRAIN_WAIT;
            row_q   <= '0;
            col_q   <= '0;
            wbank_q <= 1'b0;
            rbank_q <= 1'b0;
        end else begin
            fill_q  <= fill_d;
            drain_q <= drain_d;
            row_q   <= row_d;
            col_q   <= col_d;
            wbank_q <= wbank_d;
            rbank_q <= rbank_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < N; k++) mem[wbank_q][wr_idx][k] <= wdata[k];
        end
    end

    // outputs
    always_comb begin
        rv    = (drain_q == DRAIN_COLS);
        rlast = (drain_q == DRAIN_COLS) && (col_q == LAST);
        for (int j = 0; j < N; j++) rdata[j] = mem[rbank_q][j][col_q];
    end

    // R6: a tile completes while the other is draining only on its last column
    p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_done && drain_q == DRAIN_COLS) |-> (col_q == LAST));

    // R6: writes never land in the bank being drained
    p_bank_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && drain_q == DRAIN_COLS) |-> (wbank_q != rbank_q));

    // R7: a row without a start flag leaves an idle fill machine idle
    p_stray_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == FILL_IDLE && wv && !wsob) |=> (fill_q == FILL_IDLE));
endmodule

// File: rtl/dct2d_rowcol.sv
`timescale 1ns/1ps
// Row pass -> corner-turn memory -> column pass.
module dct2d_rowcol #(
    parameter  int N    = 8,
    parameter  int IW   = 8,
    localparam int GROW = $clog2(N),
    localparam int MW   = IW + GROW,
    localparam int OW   = MW + GROW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_sob,
    input  logic [N*IW-1:0] in_row,
    output logic            out_valid,
    output logic            out_last,
    output logic [N*OW-1:0] out_col
);
    logic signed [IW-1:0] row_in [N];
    logic signed [MW-1:0] row_q  [N];
    logic signed [MW-1:0] tp_col [N];
    logic signed [OW-1:0] col_q  [N];
    logic                 row_v, row_sob;
    logic                 tp_v, tp_last;

    for (genvar i = 0; i < N; i++) begin : g_lanes
        assign row_in[i]             = in_row[i*IW +: IW];
        assign out_col[i*OW +: OW]   = col_q[i];
    end

    dct2d_stage #(.N(N), .W(IW)) u_row_pass (
        .clk(clk), .rst_n(rst_n), .in_v(in_valid), .in_tag(in_sob), .d(row_in),
        .out_v(row_v), .out_tag(row_sob), .q(row_q)
    );

    dct2d_transpose #(.N(N), .W(MW)) u_turn (
        .clk(clk), .rst_n(rst_n), .wv(row_v), .wsob(row_sob), .wdata(row_q),
        .rv(tp_v), .rlast(tp_last), .rdata(tp_col)
    );

    dct2d_stage #(.N(N), .W(MW)) u_col_pass (
        .clk(clk), .rst_n(rst_n), .in_v(tp_v), .in_tag(tp_last), .d(tp_col),
        .out_v(out_valid), .out_tag(out_last), .q(col_q)
    );

    // R5: end-of-tile marker only on a valid column
    p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: tb/dct2d_rowcol_tb.sv
`timescale 1ns/1ps
module dct2d_rowcol_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic          v8 = 0, s8 = 0, v16 = 0, s16 = 0;
    logic [63:0]   row8  = '0;
    logic [127:0]  row16 = '0;
    logic          o_v8, o_l8, o_v16, o_l16;
    logic [111:0]  o_c8;
    logic [255:0]  o_c16;

    dct2d_rowcol #(.N(8), .IW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_sob(s8), .in_row(row8),
        .out_valid(o_v8), .out_last(o_l8), .out_col(o_c8));

    dct2d_rowcol #(.N(16), .IW(8)) u_dut16 (
        .clk(clk), .rst_n(rst_n), .in_valid(v16), .in_sob(s16), .in_row(row16),
        .out_valid(o_v16), .out_last(o_l16), .out_col(o_c16));

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R3";
    int cur [16][16];
    int q8[$];
    int q16[$];
    int vcnt8 = 0, first8 = -1, last8 = 0, col8 = 0;
    int vcnt16 = 0, col16 = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int c8(input int u, input int c);
        logic [7:0] nz, ng;
        case (u)
            0: begin nz = 8'hFF; ng = 8'h00; end
            1: begin nz = 8'hC3; ng = 8'hC0; end
            2: begin nz = 8'h99; ng = 8'h18; end
            3: begin nz = 8'h3C; ng = 8'h30; end
            4: begin nz = 8'hFF; ng = 8'h66; end
            5: begin nz = 8'h3C; ng = 8'h28; end
            6: begin nz = 8'h66; ng = 8'h24; end
            default: begin nz = 8'hC3; ng = 8'h82; end
        endcase
        if (!nz[c]) return 0;
        return ng[c] ? -1 : 1;
    endfunction

    function automatic int coef(input int n, input int u, input int c);
        if (n == 8) return c8(u, c);
        if (u % 2 == 0) return (c < 8) ? c8(u/2, c) : c8(u/2, 15-c);
        return (c < 8) ? c8((u-1)/2, c) : -c8((u-1)/2, 15-c);
    endfunction

    task automatic load(input int kind, input int seed);
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                case (kind)
                    0: cur[r][c] = ((r*37 + c*11 + seed*29) % 256) - 128;
                    1: cur[r][c] = seed;
                    2: cur[r][c] = ((r + c) % 2 == 1) ? 127 : -128;
                    default: cur[r][c] = (r == seed % 16 && c == (seed*3) % 16) ? 100 : 0;
                endcase
    endtask

    task automatic push_exp(input int n);
        int y [16][16];
        int z;
        for (int r = 0; r < n; r++)
            for (int u = 0; u < n; u++) begin
                y[r][u] = 0;
                for (int c = 0; c < n; c++) y[r][u] += coef(n, u, c) * cur[r][c];
            end
        for (int u = 0; u < n; u++)
            for (int v = 0; v < n; v++) begin
                z = 0;
                for (int r = 0; r < n; r++) z += coef(n, v, r) * y[r][u];
                if (n == 8) q8.push_back(z); else q16.push_back(z);
            end
    endtask

    task automatic drive_row(input int n, input bit sob, input int r);
        @(negedge clk);
        v8 = (n == 8); s8 = (n == 8) && sob;
        v16 = (n == 16); s16 = (n == 16) && sob;
        for (int c = 0; c < 8; c++)  row8[c*8 +: 8]  = 8'(cur[r][c]);
        for (int c = 0; c < 16; c++) row16[c*8 +: 8] = 8'(cur[r][c]);
    endtask

    task automatic idle(input int k);
        repeat (k) begin
            @(negedge clk);
            v8 = 0; s8 = 0; v16 = 0; s16 = 0;
        end
    endtask

    task automatic send_block(input int n);
        push_exp(n);
        for (int r = 0; r < n; r++) drive_row(n, r == 0, r);
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act %0d exp %0d", req, what, act, exp_v);
        end
    endtask

    // monitor, 8-point instance
    always @(negedge clk) begin : mon8
        int e, a;
        bit bad;
        if (rst_n) begin
            if (o_l8 && !o_v8) check(0, "R5", "last without valid (8)", 1, 0);
            if (o_v8) begin
                vcnt8++;
                if (first8 < 0) first8 = cyc;
                last8 = cyc;
                if (q8.size() < 8) begin
                    check(0, cur_req, "unexpected column (8)", 1, 0);
                end else begin
                    bad = 0;
                    for (int v = 0; v < 8; v++) begin
                        e = q8.pop_front();
                        a = $signed(o_c8[v*14 +: 14]);
                        if (a != e && !bad) begin
                            bad = 1;
                            check(0, cur_req, $sformatf("col %0d lane %0d (8)", col8, v), a, e);
                        end
                    end
                    if (!bad) check(1, cur_req, "", 0, 0);
                    check(o_l8 == (col8 == 7), "R5", "end-of-tile flag (8)", int'(o_l8), int'(col8 == 7));
                end
                col8 = (col8 + 1) % 8;
            end
        end
    end

    // monitor, 16-point instance
    always @(negedge clk) begin : mon16
        int e, a;
        bit bad;
        if (rst_n) begin
            if (o_l16 && !o_v16) check(0, "R5", "last without valid (16)", 1, 0);
            if (o_v16) begin
                vcnt16++;
                if (q16.size() < 16) begin
                    check(0, cur_req, "unexpected column (16)", 1, 0);
                end else begin
                    bad = 0;
                    for (int v = 0; v < 16; v++) begin
                        e = q16.pop_front();
                        a = $signed(o_c16[v*16 +: 16]);
                        if (a != e && !bad) begin
                            bad = 1;
                            check(0, cur_req, $sformatf("col %0d lane %0d (16)", col16, v), a, e);
                        end
                    end
                    if (!bad) check(1, cur_req, "", 0, 0);
                    check(o_l16 == (col16 == 15), "R5", "end-of-tile flag (16)", int'(o_l16), int'(col16 == 15));
                end
                col16 = (col16 + 1) % 16;
            end
        end
    end

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!o_v8 && !o_l8 && !o_v16 && !o_l16, "R10", "outputs in reset", int'(o_v8 | o_v16), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!o_v8 && !o_l8, "R10", "outputs after reset", int'(o_v8), 0);
    endtask

    task automatic t_basic();
        cur_req = "R1";
        load(0, 1); send_block(8); idle(14);
    endtask

    task automatic t_columns();
        cur_req = "R3";
        load(3, 2); send_block(8); idle(2);
        load(2, 0); send_block(8); idle(14);
    endtask

    task automatic t_extreme();
        cur_req = "R11";
        load(1, -128); send_block(8); idle(1);
        load(1, 127);  send_block(8); idle(14);
        load(1, -128); send_block(16); idle(22);
    endtask

    task automatic t_latency();
        int t0;
        cur_req = "R4";
        load(0, 7);
        push_exp(8);
        first8 = -1;
        drive_row(8, 1, 0);
        t0 = cyc + 1;
        for (int r = 1; r < 8; r++) drive_row(8, 0, r);
        idle(14);
        check(first8 - t0 == 9, "R4", "first column latency", first8 - t0, 9);
    endtask

    task automatic t_stream();
        int v0;
        cur_req = "R6";
        v0 = vcnt8;
        first8 = -1;
        load(0, 11); send_block(8);
        load(2, 0);  send_block(8);
        idle(16);
        check(vcnt8 - v0 == 16, "R6", "columns for two tiles", vcnt8 - v0, 16);
        check(last8 - first8 == 15, "R6", "unbroken column run", last8 - first8, 15);
    endtask

    task automatic t_stray();
        int v0;
        cur_req = "R7";
        v0 = vcnt8;
        load(0, 3);
        for (int r = 0; r < 8; r++) drive_row(8, 0, r);
        idle(20);
        check(vcnt8 == v0, "R7", "columns from stray rows", vcnt8 - v0, 0);
        load(0, 4); send_block(8); idle(14);
        check(vcnt8 - v0 == 8, "R7", "columns after stray rows", vcnt8 - v0, 8);
    endtask

    task automatic t_restart();
        int v0;
        cur_req = "R8";
        v0 = vcnt8;
        load(0, 5);
        for (int r = 0; r < 3; r++) drive_row(8, r == 0, r);
        load(0, 9); send_block(8); idle(14);
        check(vcnt8 - v0 == 8, "R8", "columns after restart", vcnt8 - v0, 8);
    endtask

    task automatic t_gaps();
        cur_req = "R9";
        load(0, 13);
        push_exp(8);
        for (int r = 0; r < 8; r++) begin
            drive_row(8, r == 0, r);
            if (r % 3 == 1) idle(2);
        end
        idle(14);
    endtask

    task automatic t_sixteen();
        int v0;
        cur_req = "R2";
        v0 = vcnt16;
        load(0, 17); send_block(16);
        load(3, 6);  send_block(16);
        idle(24);
        check(vcnt16 - v0 == 32, "R2", "columns for two 16-point tiles", vcnt16 - v0, 32);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_columns();
        t_extreme();
        t_latency();
        t_stream();
        t_stray();
        t_restart();
        t_gaps();
        t_sixteen();
        check(q8.size() == 0 && q16.size() == 0, "R3", "expected columns never produced",
              q8.size() + q16.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act hung exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule